// File: doc/BRIEF.md
# Configurable CRC-32 Accumulator

This block keeps a running 32-bit CRC behind a small register port. Software picks a starting value and a feeding width through one control word. The starting value can be a programmable seed, all zeros or all ones. Each data write then folds either a whole 32-bit word or the low byte of the write into the CRC state in a single clock cycle. The generator polynomial is fixed at 0x04C11DB7. Bits are processed most significant first, with no reflection of the data or of the result.

Two result views can be read: the raw CRC state, and a post-processed copy that is complemented bit by bit when inversion is enabled. The start selector in the control word is one-shot. It returns to zero by itself on the first data write, so a later control write that leaves the field at zero does not restart the computation. Reads are combinational from the current address; writes take effect at the clock edge.

Top module: `crc_accel`

## Requirements
- R1: The control word at offset 0x400 resets to zero. Only the start selector (bits 14:13), the byte-mode bit (bit 12) and the invert bit (bit 9) are writable. Every other bit reads zero, whatever was written.
- R2: The seed word at offset 0x410 is readable and writable and resets to zero. Writing it also loads the CRC state with the written value, which gives the "continue from seed" context.
- R3: A control write with start selector 2 loads the CRC state with 0x00000000, and selector 3 loads 0xFFFFFFFF. Selector 0 (use seed) and selector 1 (reserved) leave the CRC state unchanged.
- R4: The start selector reads back as written until the first write to the data word at 0x414. That write clears it to zero, and it stays zero until the control word is written again. The byte-mode and invert bits are kept.
- R5: With byte mode 0, a data write folds all 32 bits, bit 31 first, into the CRC with polynomial 0x04C11DB7 in one cycle. The new value is readable in the cycle after the write.
- R6: With byte mode 1, a data write folds only bits 7:0, bit 7 first. Bits 31:8 of the write have no effect.
- R7: The raw result at 0x418 returns the CRC state. The post-processed result at 0x41C returns the CRC state, or its bitwise complement when the invert bit is 1.
- R8: The data word and any unmapped offset read zero. Writes to the two result offsets change nothing.
- R9: Between register writes the CRC state holds its value, and after reset the raw result reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset within the block |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, zero when not reading |

## Verification
The assertions check the state transitions on every cycle:
- the one-shot clearing of the start selector on a data write;
- the zero and all-ones loads;
- the state staying put on selector 0 and 1;
- the seed load;
- the state holding when nothing is written.

Only the bench scenarios can show that the folded values are the right CRC. They compare word and byte feeding from every start source, with inversion on and off, against an independent bit-serial model, and they run a known check string. The bench also covers the reserved-bit masking and the ignored upper bytes and result-register writes.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned CRC_W  = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 12;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h400;
  localparam logic [ADDR_W-1:0] OFS_SEED = 12'h410;
  localparam logic [ADDR_W-1:0] OFS_DIN  = 12'h414;
  localparam logic [ADDR_W-1:0] OFS_RAW  = 12'h418;
  localparam logic [ADDR_W-1:0] OFS_POST = 12'h41C;

  localparam int unsigned START_LSB = 13;
  localparam int unsigned BYTE_BIT  = 12;
  localparam int unsigned INV_BIT   = 9;

  typedef enum logic [1:0] {
    START_SEED = 2'd0,
    START_RSVD = 2'd1,
    START_ZERO = 2'd2,
    START_ONES = 2'd3
  } start_e;

  typedef struct packed {
    start_e start;
    logic   byte_mode;
    logic   inv;
  } cfg_t;
endpackage

// File: rtl/crc_cfg_reg.sv
module crc_cfg_reg
  import crc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_we_i,
  input  logic din_we_i,
  input  cfg_t cfg_i,
  output cfg_t cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{start: START_SEED, byte_mode: 1'b0, inv: 1'b0};
    end else if (ctrl_we_i) begin
      cfg_q <= cfg_i;
    end else if (din_we_i) begin
      cfg_q.start <= START_SEED;  // one-shot selector
    end
  end

  assign cfg_o = cfg_q;

  p_init_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (din_we_i && !ctrl_we_i) |=> (cfg_q.start == START_SEED));

  p_mode_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (din_we_i && !ctrl_we_i) |=> ($stable(cfg_q.byte_mode) && $stable(cfg_q.inv)));

  p_cfg_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_we_i && !din_we_i) |=> $stable(cfg_q));
endmodule

// File: rtl/crc_fold.sv
module crc_fold #(
  parameter int unsigned              CRC_W  = 32,
  parameter int unsigned              DATA_W = 32,
  parameter int unsigned              BYTE_W = 8,
  parameter logic [CRC_W-1:0]         POLY   = 32'h04C1_1DB7
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              byte_mode_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] wch [DATA_W+1];
  logic [CRC_W-1:0] bch [BYTE_W+1];

  assign wch[0] = crc_i;
  assign bch[0] = crc_i;

  // MSB-first serial steps, unrolled
  for (genvar g = 0; g < DATA_W; g++) begin : g_word
    assign wch[g+1] = {wch[g][CRC_W-2:0], 1'b0}
                    ^ ({CRC_W{wch[g][CRC_W-1] ^ data_i[DATA_W-1-g]}} & POLY);
  end

  for (genvar g = 0; g < BYTE_W; g++) begin : g_byte
    assign bch[g+1] = {bch[g][CRC_W-2:0], 1'b0}
                    ^ ({CRC_W{bch[g][CRC_W-1] ^ data_i[BYTE_W-1-g]}} & POLY);
  end

  assign crc_o = byte_mode_i ? bch[BYTE_W] : wch[DATA_W];
endmodule

// File: rtl/crc_state.sv
module crc_state
  import crc_pkg::*;
#(
  parameter int unsigned      W_CRC  = CRC_W,
  parameter int unsigned      W_DATA = DATA_W,
  parameter int unsigned      W_BYTE = BYTE_W,
  parameter logic [W_CRC-1:0] POLY   = CRC_POLY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_we_i,
  input  logic              ctrl_we_i,
  input  start_e            start_i,
  input  logic              din_we_i,
  input  logic              byte_mode_i,
  input  logic [W_DATA-1:0] wdata_i,
  output logic [W_CRC-1:0]  seed_o,
  output logic [W_CRC-1:0]  crc_o
);
  logic [W_CRC-1:0] seed_q, crc_q, crc_next;

  crc_fold #(
    .CRC_W (W_CRC),
    .DATA_W(W_DATA),
    .BYTE_W(W_BYTE),
    .POLY  (POLY)
  ) u_fold (
    .crc_i      (crc_q),
    .data_i     (wdata_i),
    .byte_mode_i(byte_mode_i),
    .crc_o      (crc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seed_q <= '0;
    else if (seed_we_i) seed_q <= wdata_i[W_CRC-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '0;
    end else if (seed_we_i) begin
      crc_q <= wdata_i[W_CRC-1:0];
    end else if (ctrl_we_i) begin
      unique case (start_i)
        START_ZERO: crc_q <= '0;
        START_ONES: crc_q <= '1;
        default:    crc_q <= crc_q;
      endcase
    end else if (din_we_i) begin
      crc_q <= crc_next;
    end
  end

  assign seed_o = seed_q;
  assign crc_o  = crc_q;

  p_seed_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_we_i |=> (crc_q == $past(wdata_i[W_CRC-1:0])) && (seed_q == crc_q));

  p_load_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !seed_we_i && start_i == START_ZERO) |=> (crc_q == '0));

  p_load_ones_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !seed_we_i && start_i == START_ONES) |=> (crc_q == '1));

  p_keep_state_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !seed_we_i && (start_i == START_SEED || start_i == START_RSVD))
      |=> $stable(crc_q));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seed_we_i && !ctrl_we_i && !din_we_i) |=> $stable(crc_q));
endmodule

// File: rtl/crc_accel.sv
module crc_accel
  import crc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic wr, rd;
  logic ctrl_we, seed_we, din_we;
  cfg_t cfg_wr, cfg_q;
  logic [CRC_W-1:0] seed_q, crc_q, crc_post;
  logic [DW-1:0] ctrl_word;

  assign wr = sel_i & we_i;
  assign rd = sel_i & ~we_i;

  assign ctrl_we = wr && (addr_i == OFS_CTRL);
  assign seed_we = wr && (addr_i == OFS_SEED);
  assign din_we  = wr && (addr_i == OFS_DIN);

  assign cfg_wr.start     = start_e'(wdata_i[START_LSB +: 2]);
  assign cfg_wr.byte_mode = wdata_i[BYTE_BIT];
  assign cfg_wr.inv       = wdata_i[INV_BIT];

  crc_cfg_reg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_we_i(ctrl_we),
    .din_we_i (din_we),
    .cfg_i    (cfg_wr),
    .cfg_o    (cfg_q)
  );

  crc_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .seed_we_i  (seed_we),
    .ctrl_we_i  (ctrl_we),
    .start_i    (cfg_wr.start),
    .din_we_i   (din_we),
    .byte_mode_i(cfg_q.byte_mode),
    .wdata_i    (wdata_i),
    .seed_o     (seed_q),
    .crc_o      (crc_q)
  );

  assign crc_post = crc_q ^ {CRC_W{cfg_q.inv}};

  always_comb begin
    ctrl_word = '0;
    ctrl_word[START_LSB +: 2] = cfg_q.start;
    ctrl_word[BYTE_BIT]       = cfg_q.byte_mode;
    ctrl_word[INV_BIT]        = cfg_q.inv;
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        OFS_CTRL: rdata_o = ctrl_word;
        OFS_SEED: rdata_o = seed_q;
        OFS_RAW:  rdata_o = crc_q;
        OFS_POST: rdata_o = crc_post;
        default:  rdata_o = '0;
      endcase
    end
  end

  p_rsvd_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == OFS_CTRL) |-> ((rdata_o & ~32'h0000_7200) == '0));

  p_no_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |-> (rdata_o == '0));
endmodule

// File: tb/sim_crc_accel.sv
`timescale 1ns/1ps
module sim_crc_accel;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;
  localparam logic [11:0] A_CTRL = 12'h400, A_SEED = 12'h410, A_DIN = 12'h414,
                          A_RAW = 12'h418, A_POST = 12'h41C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  crc_accel u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  typedef struct packed {
    logic [1:0]  init;
    logic        sz;
    logic        inv;
    logic [31:0] seed;
    logic [31:0] d0;
    logic [31:0] d1;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 1'b0, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_0001},
    '{2'd2, 1'b0, 1'b0, 32'hAAAA_AAAA, 32'h1111_1111, 32'h8000_0000},
    '{2'd3, 1'b0, 1'b1, 32'h0000_0000, 32'hCAFE_F00D, 32'hFFFF_FFFF},
    '{2'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_0031, 32'h0000_0032},
    '{2'd2, 1'b1, 1'b0, 32'h0000_0055, 32'hFFFF_FFA5, 32'h0000_005A},
    '{2'd3, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0061, 32'h0000_0062},
    '{2'd1, 1'b0, 1'b0, 32'h0BAD_F00D, 32'h0102_0304, 32'h0000_0000},
    '{2'd3, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000}
  };

  function automatic logic [31:0] ref_fold(input logic [31:0] c, input logic [31:0] d,
                                           input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      logic fb;
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, exp, st, tmp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 R1 R2: reset values
    rd(A_CTRL, v); check("R1 ctrl reset", v, 32'h0);
    rd(A_SEED, v); check("R2 seed reset", v, 32'h0);
    rd(A_RAW, v);  check("R9 raw reset", v, 32'h0);
    rd(A_POST, v); check("R7 post reset", v, 32'h0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      int nb;
      nb = VEC[k].sz ? 8 : 32;
      st = (VEC[k].init == 2'd2) ? 32'h0 :
           (VEC[k].init == 2'd3) ? 32'hFFFF_FFFF : VEC[k].seed;
      wr(A_SEED, VEC[k].seed);
      wr(A_CTRL, {17'b0, VEC[k].init, VEC[k].sz, 2'b0, VEC[k].inv, 9'b0});
      rd(A_RAW, v); check($sformatf("R3 start vec%0d", k), v, st);
      wr(A_DIN, VEC[k].d0);
      rd(A_CTRL, v);
      check($sformatf("R4 init cleared vec%0d", k), v,
            {17'b0, 2'b00, VEC[k].sz, 2'b0, VEC[k].inv, 9'b0});
      wr(A_DIN, VEC[k].d1);
      exp = ref_fold(ref_fold(st, VEC[k].d0, nb), VEC[k].d1, nb);
      rd(A_RAW, v);  check($sformatf("R5 R6 raw vec%0d", k), v, exp);
      rd(A_POST, v); check($sformatf("R7 post vec%0d", k), v, VEC[k].inv ? ~exp : exp);
    end

    // R4: selector reads back before any data write
    wr(A_CTRL, 32'h0000_4000);
    rd(A_CTRL, v); check("R4 init held", v, 32'h0000_4000);

    // R1: reserved bits masked; selector 3 loads ones (R3)
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R1 reserved zero", v, 32'h0000_7200);
    rd(A_RAW, v);  check("R3 ones load", v, 32'hFFFF_FFFF);
    rd(A_POST, v); check("R7 post inverted ones", v, 32'h0);

    // R6: known check string in byte mode from all ones
    wr(A_CTRL, 32'h0000_7000);
    for (int b = 0; b < 9; b++) wr(A_DIN, 32'h31 + b);
    rd(A_RAW, v); check("R6 check string", v, 32'h0376_E6E7);

    // R6: upper bits ignored
    wr(A_CTRL, 32'h0000_5000);
    wr(A_DIN, 32'hABCD_EF12);
    rd(A_RAW, v); check("R6 upper ignored", v, ref_fold(32'h0, 32'h12, 8));

    // R8: result writes ignored, data and unmapped read zero
    rd(A_RAW, tmp);
    wr(A_RAW, 32'h5555_5555);
    wr(A_POST, 32'h1234_0000);
    rd(A_RAW, v);  check("R8 result write ignored", v, tmp);
    rd(A_DIN, v);  check("R8 data reads zero", v, 32'h0);
    rd(12'h404, v); check("R8 unmapped zero", v, 32'h0);

    // R3: selector 0 leaves state
    wr(A_CTRL, 32'h0000_0000);
    rd(A_RAW, v); check("R3 selector0 keeps", v, tmp);

    // R9: state holds while idle
    repeat (10) @(negedge clk);
    rd(A_RAW, v); check("R9 idle hold", v, tmp);

    // R4: a control write that leaves the selector at 0 does not restart
    wr(A_DIN, 32'h0000_0077);
    rd(A_RAW, st);
    wr(A_CTRL, 32'h0000_0000);
    rd(A_RAW, v); check("R4 no restart", v, st);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule